// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between an in-order load/store pipeline and the write port of a write-back data cache. Stores are parked in a small queue instead of going straight to the cache. They leave for the cache one at a time, oldest first, whenever the cache accepts a write. Loads run ahead of older parked stores that target other words. A load that targets a parked word is answered per byte from the youngest parked store that wrote that byte. Bytes that no parked store wrote are read from the cache.

A command input carries three kinds of ordering operation. A full fence holds back every later load and store until the queue is empty. A store fence holds back only later stores. A locked exchange waits for an empty queue. It then reads the old word and writes the new word in one marked cache access, and returns the old word on the load response channel.

Top module: `tso_store_buffer`

## Requirements
- R1: An accepted store is held in the queue and does not reach the cache write port until it is the oldest entry. `sb_full_o` rises when DEPTH entries are held, and `st_ready_o` is then low.
- R2: Entries leave on the cache write port in issue order, one per cycle while `cw_ready_i` is high. The presented address, data and byte enables stay unchanged while `cw_ready_i` is low.
- R3: A load whose word has no queued entry covering any of its requested bytes is accepted. It returns the cache word even when older stores to other words are still queued.
- R4: A load is answered one cycle after acceptance on `rsp_valid_o`/`rsp_data_o`. The response word holds, for each byte lane b (data bits 8b+7 down to 8b), the byte of the youngest queued store to that word whose enable bit b is set. Lanes that no such store wrote hold the cache byte.
- R5: A load whose requested byte enables are only partly covered by queued stores to its word is not accepted (`ld_ready_o` low) until coverage becomes full or empty.
- R6: When a store and a load are presented in the same cycle, the store is taken as older and the load is not accepted in that cycle.
- R7: A store accepted after a load does not change that load's response.
- R8: Command kind 0 (full fence; kind 3 behaves the same) completes (`cmd_ready_o`) only in a cycle where the queue is empty. While it is pending, `st_ready_o` and `ld_ready_o` are low.
- R9: Command kind 1 (store fence) completes only when the queue is empty. While it is pending, stores are refused and loads proceed normally.
- R10: Command kind 2 (locked exchange) waits for an empty queue. It then presents one write of `lk_data_i` to `lk_addr_i` with all byte enables and `cw_lock_o` high, and completes when that write is accepted. The old word read in that cycle appears on the response channel one cycle later.
- R11: After reset the queue is empty, `sb_full_o`, `cw_valid_o` and `rsp_valid_o` are low, and `st_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | DW | Store data |
| st_be_i | input | DW/8 | Store byte enables |
| st_ready_o | output | 1 | Store accepted this cycle when high |
| ld_valid_i | input | 1 | Load request |
| ld_addr_i | input | AW | Load word address |
| ld_be_i | input | DW/8 | Requested load bytes |
| ld_ready_o | output | 1 | Load accepted this cycle when high |
| rsp_valid_o | output | 1 | Load or exchange response valid |
| rsp_data_o | output | DW | Response word |
| cmd_valid_i | input | 1 | Ordering command pending |
| cmd_kind_i | input | 2 | 0 full fence, 1 store fence, 2 locked exchange, 3 full fence |
| lk_addr_i | input | AW | Exchange word address |
| lk_data_i | input | DW | Exchange new word |
| cmd_ready_o | output | 1 | Command completes this cycle |
| rd_addr_o | output | AW | Cache read address |
| rd_data_i | input | DW | Cache read data, same cycle |
| cw_valid_o | output | 1 | Cache write request |
| cw_ready_i | input | 1 | Cache accepts write |
| cw_addr_o | output | AW | Cache write address |
| cw_data_o | output | DW | Cache write data |
| cw_be_o | output | DW/8 | Cache write byte enables |
| cw_lock_o | output | 1 | Write is the indivisible exchange access |
| sb_empty_o | output | 1 | Queue holds no entry |
| sb_full_o | output | 1 | Queue holds DEPTH entries |

## Verification
A corrupted head pointer or entry store shows at the cache write port on the next accepted write, as a wrong address or data or out-of-order drain. It also shows one cycle later in the data of any load to that word. A wrong occupancy count shows at once on `sb_full_o`/`st_ready_o`, or as an extra or missing drain cycle. A wrong coverage decision shows in the same cycle as a stalled or wrongly accepted load. A wrong youngest-entry choice shows in the response word one cycle after acceptance. Fence and exchange gating errors show as `cmd_ready_o` or `cw_lock_o` rising while entries remain.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;
  typedef enum logic [1:0] {
    CMD_FULL  = 2'd0,
    CMD_STORE = 2'd1,
    CMD_LOCK  = 2'd2,
    CMD_RSVD  = 2'd3
  } sb_cmd_e;
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [AW-1:0]       push_addr_i,
  input  logic [DW-1:0]       push_data_i,
  input  logic [DW/8-1:0]     push_be_i,
  input  logic                pop_i,
  output logic [AW-1:0]       ord_addr_o [DEPTH],
  output logic [DW-1:0]       ord_data_o [DEPTH],
  output logic [DW/8-1:0]     ord_be_o   [DEPTH],
  output logic [DEPTH-1:0]    ord_vld_o,
  output logic                empty_o,
  output logic                full_o
);
  localparam int NB = DW / 8;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem_addr [DEPTH];
  logic [DW-1:0] mem_data [DEPTH];
  logic [NB-1:0] mem_be   [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      mem_addr[tail_q] <= push_addr_i;
      mem_data[tail_q] <= push_data_i;
      mem_be[tail_q]   <= push_be_i;
    end
  end

  // entries presented oldest first
  for (genvar k = 0; k < DEPTH; k++) begin : g_ord
    logic [PW-1:0] idx;
    assign idx           = PW'((int'(head_q) + k) % DEPTH);
    assign ord_addr_o[k] = mem_addr[idx];
    assign ord_data_o[k] = mem_data[idx];
    assign ord_be_o[k]   = mem_be[idx];
    assign ord_vld_o[k]  = (k < int'(cnt_q));
  end

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i || pop_i);
  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [DW/8-1:0]  ld_be_i,
  input  logic [AW-1:0]    e_addr_i [DEPTH],
  input  logic [DW-1:0]    e_data_i [DEPTH],
  input  logic [DW/8-1:0]  e_be_i   [DEPTH],
  input  logic [DEPTH-1:0] e_vld_i,
  input  logic [DW-1:0]    base_i,
  output logic [DW-1:0]    data_o,
  output logic [DW/8-1:0]  cov_o,
  output logic             partial_o
);
  localparam int NB = DW / 8;

  logic [DEPTH-1:0] hit;
  for (genvar k = 0; k < DEPTH; k++) begin : g_hit
    assign hit[k] = e_vld_i[k] && (e_addr_i[k] == ld_addr_i);
  end

  // per lane: later (younger) entries override earlier ones
  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_comb begin
      cov_o[b]       = 1'b0;
      data_o[8*b+:8] = base_i[8*b+:8];
      for (int k = 0; k < DEPTH; k++) begin
        if (hit[k] && e_be_i[k][b]) begin
          cov_o[b]       = 1'b1;
          data_o[8*b+:8] = e_data_i[k][8*b+:8];
        end
      end
    end
  end

  logic some_cov, some_gap;
  assign some_cov  = |(ld_be_i & cov_o);
  assign some_gap  = |(ld_be_i & ~cov_o);
  assign partial_o = some_cov && some_gap;

  // R5
  always_comb begin
    cov_lane_chk: assert (!(|cov_o) || (|hit));
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
  import tso_sb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_valid_i,
  input  logic [AW-1:0]    st_addr_i,
  input  logic [DW-1:0]    st_data_i,
  input  logic [DW/8-1:0]  st_be_i,
  output logic             st_ready_o,
  input  logic             ld_valid_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [DW/8-1:0]  ld_be_i,
  output logic             ld_ready_o,
  output logic             rsp_valid_o,
  output logic [DW-1:0]    rsp_data_o,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_kind_i,
  input  logic [AW-1:0]    lk_addr_i,
  input  logic [DW-1:0]    lk_data_i,
  output logic             cmd_ready_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [DW-1:0]    rd_data_i,
  output logic             cw_valid_o,
  input  logic             cw_ready_i,
  output logic [AW-1:0]    cw_addr_o,
  output logic [DW-1:0]    cw_data_o,
  output logic [DW/8-1:0]  cw_be_o,
  output logic             cw_lock_o,
  output logic             sb_empty_o,
  output logic             sb_full_o
);
  localparam int NB = DW / 8;

  logic [AW-1:0]    e_addr [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [NB-1:0]    e_be   [DEPTH];
  logic [DEPTH-1:0] e_vld;
  logic             empty, full, push, pop;
  logic [DW-1:0]    fwd_data;
  logic [NB-1:0]    fwd_cov;
  logic             partial;
  sb_cmd_e          kind;
  logic             is_lock, is_sfence, is_mfence, lock_go, lock_fire, ld_fire;
  logic             rsp_valid_q;
  logic [DW-1:0]    rsp_data_q;

  assign kind      = sb_cmd_e'(cmd_kind_i);
  assign is_lock   = cmd_valid_i && (kind == CMD_LOCK);
  assign is_sfence = cmd_valid_i && (kind == CMD_STORE);
  assign is_mfence = cmd_valid_i && !is_lock && !is_sfence;

  assign st_ready_o = !full && !cmd_valid_i;
  assign push       = st_valid_i && st_ready_o;
  assign pop        = !empty && cw_ready_i;

  // same-cycle store is older than the load
  assign ld_ready_o = !(is_lock || is_mfence || st_valid_i || partial);
  assign ld_fire    = ld_valid_i && ld_ready_o;

  assign lock_go   = is_lock && empty;
  assign lock_fire = lock_go && cw_ready_i;
  assign cmd_ready_o = is_lock ? lock_fire : (cmd_valid_i && empty);

  assign rd_addr_o  = is_lock ? lk_addr_i : ld_addr_i;
  assign cw_valid_o = !empty || lock_go;
  assign cw_lock_o  = lock_go;
  assign cw_addr_o  = empty ? lk_addr_i : e_addr[0];
  assign cw_data_o  = empty ? lk_data_i : e_data[0];
  assign cw_be_o    = empty ? '1 : e_be[0];

  sb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_addr_i(st_addr_i),
    .push_data_i(st_data_i),
    .push_be_i  (st_be_i),
    .pop_i      (pop),
    .ord_addr_o (e_addr),
    .ord_data_o (e_data),
    .ord_be_o   (e_be),
    .ord_vld_o  (e_vld),
    .empty_o    (empty),
    .full_o     (full)
  );

  sb_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
    .ld_addr_i(ld_addr_i),
    .ld_be_i  (ld_be_i),
    .e_addr_i (e_addr),
    .e_data_i (e_data),
    .e_be_i   (e_be),
    .e_vld_i  (e_vld),
    .base_i   (rd_data_i),
    .data_o   (fwd_data),
    .cov_o    (fwd_cov),
    .partial_o(partial)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= ld_fire || lock_fire;
      if (ld_fire)        rsp_data_q <= fwd_data;
      else if (lock_fire) rsp_data_q <= rd_data_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign sb_empty_o  = empty;
  assign sb_full_o   = full;

  // R2
  cw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_valid_o && !cw_ready_i && !cw_lock_o |=>
      cw_valid_o && $stable(cw_addr_o) && $stable(cw_data_o) && $stable(cw_be_o));
  // R4
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && ld_ready_o |=> rsp_valid_o);
  // R8
  fence_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |-> sb_empty_o);
  // R8
  fence_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_kind_i != 2'd1 |-> !ld_ready_o && !st_ready_o);
  // R10
  lock_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_kind_i == 2'd2 && cmd_ready_o |-> cw_valid_o && cw_lock_o && cw_ready_i);
  // R6
  ld_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |-> !ld_ready_o);
endmodule

// File: tb/sim_tso_store_buffer.sv
`timescale 1ns/100ps
module sim_tso_store_buffer;
  localparam int AW = 3, DW = 32, DEPTH = 4, NB = 4, NW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic st_valid_i = 0, ld_valid_i = 0, cmd_valid_i = 0, cw_ready_i = 0;
  logic [AW-1:0] st_addr_i = 0, ld_addr_i = 0, lk_addr_i = 0;
  logic [DW-1:0] st_data_i = 0, lk_data_i = 0;
  logic [NB-1:0] st_be_i = 0, ld_be_i = 0;
  logic [1:0] cmd_kind_i = 0;
  logic st_ready_o, ld_ready_o, rsp_valid_o, cmd_ready_o, cw_valid_o, cw_lock_o;
  logic sb_empty_o, sb_full_o;
  logic [DW-1:0] rsp_data_o, cw_data_o, rd_data_i;
  logic [AW-1:0] rd_addr_o, cw_addr_o;
  logic [NB-1:0] cw_be_o;

  always #2.5 clk_i = ~clk_i;

  tso_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

  int checks = 0, errors = 0;
  logic [DW-1:0] cache [NW];
  logic [DW-1:0] ref_mem [NW];
  logic [AW-1:0] qa [$];
  logic [DW-1:0] qd [$];
  logic [NB-1:0] qb [$];
  logic auto_rdy = 0;
  logic [15:0] rs = 16'hACE1, rr = 16'h1D2B;

  function automatic logic [DW-1:0] init_word(input int a);
    return 32'h1111_1111 * (a + 1);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NW; a++) cache[a] <= init_word(a);
    end else if (cw_valid_o && cw_ready_i) begin
      for (int b = 0; b < NB; b++)
        if (cw_be_o[b]) cache[cw_addr_o][8*b+:8] <= cw_data_o[8*b+:8];
    end
  end
  assign rd_data_i = cache[rd_addr_o];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drain order monitor
  always @(negedge clk_i) begin
    #1.5;
    if (rst_ni && cw_valid_o && cw_ready_i) begin
      if (cw_lock_o) chk(qa.size() == 0, "R10 lock with queued entries", DW'(qa.size()), 0);
      else if (qa.size() == 0) chk(0, "R2 drain from empty model", 1, 0);
      else begin
        chk(cw_addr_o == qa[0] && cw_data_o == qd[0] && cw_be_o == qb[0],
            "R2 drain order", cw_data_o, qd[0]);
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qb.pop_front());
      end
    end
  end

  always @(negedge clk_i) if (auto_rdy) begin
    rr = {rr[14:0], rr[15] ^ rr[13] ^ rr[12] ^ rr[10]};
    cw_ready_i = rr[0] | rr[3];
  end

  function automatic logic [NB-1:0] cover_of(input logic [AW-1:0] a);
    logic [NB-1:0] c = '0;
    foreach (qa[i]) if (qa[i] == a) c |= qb[i];
    return c;
  endfunction

  task automatic do_st(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] be);
    @(negedge clk_i);
    st_valid_i = 1; st_addr_i = a; st_data_i = d; st_be_i = be;
    #1;
    while (!st_ready_o) begin @(negedge clk_i); #1; end
    for (int b = 0; b < NB; b++) if (be[b]) ref_mem[a][8*b+:8] = d[8*b+:8];
    qa.push_back(a); qd.push_back(d); qb.push_back(be);
    @(negedge clk_i);
    st_valid_i = 0;
  endtask

  task automatic do_ld(input logic [AW-1:0] a, input logic [NB-1:0] be);
    logic [NB-1:0] cv;
    logic stall;
    logic [DW-1:0] exp;
    @(negedge clk_i);
    ld_valid_i = 1; ld_addr_i = a; ld_be_i = be;
    #1;
    cv = cover_of(a);
    stall = |(be & cv) && |(be & ~cv);
    chk(ld_ready_o == !stall, stall ? "R5 partial stall" : "R3 accept", DW'(ld_ready_o), DW'(!stall));
    if (ld_ready_o) begin
      exp = ref_mem[a];
      @(negedge clk_i);
      ld_valid_i = 0;
      #1;
      chk(rsp_valid_o && rsp_data_o == exp, ((be & cv) == 0) ? "R3 bypass data" : "R4 forward data",
          rsp_data_o, exp);
    end else ld_valid_i = 0;
  endtask

  task automatic wait_empty(output int n);
    n = 0;
    do begin @(negedge clk_i); #1; n++; end while (!sb_empty_o && n < 1000);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [DW-1:0] old;
    for (int a = 0; a < NW; a++) ref_mem[a] = init_word(a);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i); #1;
    // R11 reset state
    chk(sb_empty_o && !sb_full_o && !cw_valid_o && !rsp_valid_o && st_ready_o, "R11 reset",
        {sb_empty_o, sb_full_o, cw_valid_o, rsp_valid_o, st_ready_o}, 5'b10001);

    // R1 fill with drain blocked
    do_st(1, 32'hA1A2A3A4, 4'hF);
    do_st(1, 32'hB1B2B3B4, 4'h6);
    do_st(2, 32'hC1C2C3C4, 4'h3);
    do_st(3, 32'hD1D2D3D4, 4'h5);
    #1;
    chk(sb_full_o && !st_ready_o, "R1 full", {sb_full_o, st_ready_o}, 2'b10);
    chk(cache[1] == init_word(1) && !cw_ready_i, "R1 not in cache", cache[1], init_word(1));
    // sweep every word and byte mask
    for (int a = 0; a < NW; a++)
      for (int be = 1; be < 16; be++) do_ld(AW'(a), NB'(be));

    // R2 drain one per cycle
    @(negedge clk_i); cw_ready_i = 1; #1;
    n = 0;
    while (!sb_empty_o && n < 100) begin @(negedge clk_i); #1; n++; end
    chk(n == 4, "R2 drain rate", n, 4);
    for (int a = 0; a < NW; a++) chk(cache[a] == ref_mem[a], "R2 cache image", cache[a], ref_mem[a]);

    // mixed traffic with ragged cache acceptance
    auto_rdy = 1;
    for (int i = 0; i < 600; i++) begin
      rs = {rs[14:0], rs[15] ^ rs[13] ^ rs[12] ^ rs[10]};
      if (rs[0]) do_st(rs[3:1], {rs, rs ^ 16'h5A5A}, (rs[7:4] == 0) ? 4'h8 : rs[7:4]);
      else do_ld(rs[3:1], (rs[11:8] == 0) ? 4'hF : rs[11:8]);
    end
    auto_rdy = 0;
    @(negedge clk_i); cw_ready_i = 1;
    wait_empty(n);
    for (int a = 0; a < NW; a++) chk(cache[a] == ref_mem[a], "R2 cache after mix", cache[a], ref_mem[a]);

    // R6 same-cycle store and load
    @(negedge clk_i); cw_ready_i = 0;
    st_valid_i = 1; st_addr_i = 6; st_data_i = 32'h66; st_be_i = 4'hF;
    ld_valid_i = 1; ld_addr_i = 5; ld_be_i = 4'hF;
    #1;
    chk(!ld_ready_o && st_ready_o, "R6 store first", {ld_ready_o, st_ready_o}, 2'b01);
    ref_mem[6] = 32'h66; qa.push_back(6); qd.push_back(32'h66); qb.push_back(4'hF);
    @(negedge clk_i); st_valid_i = 0; ld_valid_i = 0;

    // R7 load then younger store to same word
    @(negedge clk_i);
    ld_valid_i = 1; ld_addr_i = 5; ld_be_i = 4'hF; old = ref_mem[5];
    #1; chk(ld_ready_o, "R7 load accepted", DW'(ld_ready_o), 1);
    @(negedge clk_i); ld_valid_i = 0;
    st_valid_i = 1; st_addr_i = 5; st_data_i = 32'h55AA55AA; st_be_i = 4'hF;
    #1;
    chk(rsp_valid_o && rsp_data_o == old, "R7 old value", rsp_data_o, old);
    ref_mem[5] = 32'h55AA55AA; qa.push_back(5); qd.push_back(32'h55AA55AA); qb.push_back(4'hF);
    @(negedge clk_i); st_valid_i = 0;

    // R8 full fence with two queued entries
    @(negedge clk_i);
    cmd_valid_i = 1; cmd_kind_i = 2'd0; st_valid_i = 0; ld_valid_i = 1; ld_addr_i = 0; ld_be_i = 4'hF;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(!cmd_ready_o && !ld_ready_o && !st_ready_o, "R8 fence holds",
          {cmd_ready_o, ld_ready_o, st_ready_o}, 0);
      @(negedge clk_i);
    end
    ld_valid_i = 0; cw_ready_i = 1; #1;
    n = 0;
    while (!cmd_ready_o && n < 100) begin @(negedge clk_i); #1; n++; end
    chk(n == 2 && sb_empty_o, "R8 fence completes when empty", n, 2);
    @(negedge clk_i); cmd_valid_i = 0; cw_ready_i = 0;

    // R9 store fence: stores wait, loads pass
    do_st(4, 32'h44444444, 4'hF);
    @(negedge clk_i);
    cmd_valid_i = 1; cmd_kind_i = 2'd1; #1;
    chk(!st_ready_o && !cmd_ready_o, "R9 stores held", {st_ready_o, cmd_ready_o}, 0);
    do_ld(6, 4'hF);
    do_ld(4, 4'hF);
    #1; chk(!cmd_ready_o, "R9 not done while queued", DW'(cmd_ready_o), 0);
    @(negedge clk_i); cw_ready_i = 1; #1;
    n = 0;
    while (!cmd_ready_o && n < 100) begin @(negedge clk_i); #1; n++; end
    chk(n == 1 && sb_empty_o, "R9 fence completes", n, 1);
    @(negedge clk_i); cmd_valid_i = 0; cw_ready_i = 0;

    // R10 locked exchange behind queued stores
    do_st(7, 32'h77007700, 4'h5);
    do_st(7, 32'h00880088, 4'h2);
    @(negedge clk_i);
    cmd_valid_i = 1; cmd_kind_i = 2'd2; lk_addr_i = 7; lk_data_i = 32'hFEEDF00D; #1;
    chk(!cw_lock_o && !cmd_ready_o, "R10 waits for drain", {cw_lock_o, cmd_ready_o}, 0);
    @(negedge clk_i); cw_ready_i = 1; #1;
    n = 0;
    while (!cmd_ready_o && n < 100) begin @(negedge clk_i); #1; n++; end
    chk(cw_lock_o && cw_addr_o == 7 && cw_data_o == 32'hFEEDF00D && cw_be_o == 4'hF,
        "R10 locked write", cw_data_o, 32'hFEEDF00D);
    old = ref_mem[7]; ref_mem[7] = 32'hFEEDF00D;
    @(negedge clk_i); cmd_valid_i = 0; cw_ready_i = 0; #1;
    chk(rsp_valid_o && rsp_data_o == old, "R10 old word returned", rsp_data_o, old);
    do_ld(7, 4'hF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule